// File: doc/BRIEF.md
# Register Window Controller

This block holds the control state of a windowed register file: the current window pointer and two occupancy counters. The first counter is the number of windows that can still be entered before a spill is needed. The second is the number of windows that can be left before a fill is needed. The sum of the two stays at the window count minus two.

Each cycle the pipeline may present at most one window operation: a call-side save, or one of two return-side operations. For each operation the block decides one of three outcomes. It can move the pointer and enable the destination write. It can raise a spill, fill or clean-window trap, still moving the pointer. Or, for a misaligned return, it can raise an alignment trap and leave everything unchanged.

The clean-window count and the other-context count come in from the surrounding privileged state. The spill and fill vector selector is taken from one of two 3-bit halves of a 6-bit state field. All results appear one cycle after the operation is sampled.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the pointer is 0, the save counter is NWIN-2, the restore counter is 0, and rd_we, trap_req, trap_kind, trap_other and trap_vec are all 0.
- R2: An operation is sampled on a rising edge with op_valid high. op_kind 01 is save, 10 is restore, 11 is return, and 00 does nothing. With op_valid low, or op_kind 00, no state changes and no trap or write is signalled. Results appear on the outputs after that same edge.
- R3: A save with a nonzero save counter, and a clean-window count unequal to the restore counter, advances the pointer by one modulo NWIN. It decrements the save counter, increments the restore counter and pulses rd_we.
- R4: A save with a save counter of 0 raises a spill trap (trap_kind 1) and moves the pointer by two modulo NWIN, leaving both counters unchanged. A spill takes priority over the clean-window condition.
- R5: A save with a nonzero save counter, and a clean-window count equal to the restore counter, advances the pointer by one. It raises a clean-window trap (trap_kind 3) with trap_vec 0 and trap_other 0, and leaves both counters unchanged.
- R6: A restore, or an aligned return, moves the pointer to (pointer-1+NWIN) modulo NWIN. With a nonzero restore counter it increments the save counter, decrements the restore counter and pulses rd_we. The two counters always sum to NWIN-2.
- R7: A restore, or an aligned return, with a restore counter of 0 raises a fill trap (trap_kind 2). It still moves the pointer down by one and leaves both counters unchanged.
- R8: For spill and fill traps, trap_other is 1 and trap_vec is wstate[5:3] when otherwin is nonzero. Otherwise trap_other is 0 and trap_vec is wstate[2:0].
- R9: A return with a nonzero tgt_lo raises an alignment trap (trap_kind 4, trap_vec 0, trap_other 0) and changes neither the pointer nor the counters. This takes priority over a fill.
- R10: trap_req is high exactly when trap_kind is nonzero. It lasts one cycle per operation, and rd_we is never high together with trap_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 2 | 01 save, 10 restore, 11 return |
| tgt_lo | input | 2 | Low two bits of the return target address |
| wstate | input | 6 | Vector selector pair: [5:3] other, [2:0] normal |
| cleanwin | input | $clog2(NWIN) | Clean-window count |
| otherwin | input | $clog2(NWIN) | Windows owned by another context |
| cwp | output | $clog2(NWIN) | Current window pointer |
| cansave | output | $clog2(NWIN) | Windows enterable before a spill |
| canrestore | output | $clog2(NWIN) | Windows leavable before a fill |
| rd_we | output | 1 | Destination write enable pulse |
| trap_req | output | 1 | Trap request pulse |
| trap_kind | output | 3 | 0 none, 1 spill, 2 fill, 3 clean, 4 alignment |
| trap_other | output | 1 | Trap is of the other-context kind |
| trap_vec | output | 3 | Spill or fill vector selector |

## Verification
Two conflicts can arise in the same cycle, and each has a fixed winner.

The first is a save that finds both a zero save counter and a clean-window count equal to the restore counter. The bench provokes it by saving until the save counter is exhausted, then issuing a save with the clean-window input set to the current restore count. The spill outcome must win, with the pointer moved by two.

The second is a return that is misaligned while the restore counter is zero. The bench provokes it by issuing misaligned returns after the restore counter has reached zero. The alignment trap must win, with the pointer and both counters unchanged.

// File: rtl/regwin_ctrl.sv
module regwin_ctrl #(
  parameter int NWIN = 8,
  localparam int CW = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic [1:0]    tgt_lo,
  input  logic [5:0]    wstate,
  input  logic [CW-1:0] cleanwin,
  input  logic [CW-1:0] otherwin,
  output logic [CW-1:0] cwp,
  output logic [CW-1:0] cansave,
  output logic [CW-1:0] canrestore,
  output logic          rd_we,
  output logic          trap_req,
  output logic [2:0]    trap_kind,
  output logic          trap_other,
  output logic [2:0]    trap_vec
);
  localparam logic [2:0] K_NONE  = 3'd0;
  localparam logic [2:0] K_SPILL = 3'd1;
  localparam logic [2:0] K_FILL  = 3'd2;
  localparam logic [2:0] K_CLEAN = 3'd3;
  localparam logic [2:0] K_ALIGN = 3'd4;
  localparam logic [CW:0] NW = (CW+1)'(NWIN);

  logic is_save, is_back, misal;
  assign is_save = op_valid && (op_kind == 2'b01);
  assign is_back = op_valid && op_kind[1];
  assign misal   = is_back && op_kind[0] && (tgt_lo != 2'b00);

  logic [CW:0] up1, up2;
  logic [CW-1:0] cwp_p1, cwp_p2, cwp_m1;
  assign up1    = {1'b0, cwp} + (CW+1)'(1);
  assign up2    = {1'b0, cwp} + (CW+1)'(2);
  assign cwp_p1 = (up1 >= NW) ? CW'(up1 - NW) : CW'(up1);
  assign cwp_p2 = (up2 >= NW) ? CW'(up2 - NW) : CW'(up2);
  assign cwp_m1 = (cwp == '0) ? CW'(NWIN - 1) : cwp - CW'(1);

  logic       sel_other;
  logic [2:0] sel_vec;
  assign sel_other = (otherwin != '0);
  assign sel_vec   = sel_other ? wstate[5:3] : wstate[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp        <= '0;
      cansave    <= CW'(NWIN - 2);
      canrestore <= '0;
      rd_we      <= 1'b0;
      trap_req   <= 1'b0;
      trap_kind  <= K_NONE;
      trap_other <= 1'b0;
      trap_vec   <= 3'd0;
    end else begin
      rd_we      <= 1'b0;
      trap_req   <= 1'b0;
      trap_kind  <= K_NONE;
      trap_other <= 1'b0;
      trap_vec   <= 3'd0;
      if (is_save) begin
        if (cansave == '0) begin
          cwp        <= cwp_p2;
          trap_req   <= 1'b1;
          trap_kind  <= K_SPILL;
          trap_other <= sel_other;
          trap_vec   <= sel_vec;
        end else if (cleanwin == canrestore) begin
          cwp       <= cwp_p1;
          trap_req  <= 1'b1;
          trap_kind <= K_CLEAN;
        end else begin
          cwp        <= cwp_p1;
          cansave    <= cansave - CW'(1);
          canrestore <= canrestore + CW'(1);
          rd_we      <= 1'b1;
        end
      end else if (misal) begin
        trap_req  <= 1'b1;
        trap_kind <= K_ALIGN;
      end else if (is_back) begin
        cwp <= cwp_m1;
        if (canrestore == '0) begin
          trap_req   <= 1'b1;
          trap_kind  <= K_FILL;
          trap_other <= sel_other;
          trap_vec   <= sel_vec;
        end else begin
          cansave    <= cansave + CW'(1);
          canrestore <= canrestore - CW'(1);
          rd_we      <= 1'b1;
        end
      end
    end
  end

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_kind == 2'b00) |=> (!trap_req && !rd_we && $stable(cwp)));
  p_save_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_save && cansave != '0 && cleanwin != canrestore)
      |=> (rd_we && cansave == $past(cansave) - CW'(1)));
  p_spill_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_save && cansave == '0) |=> (trap_req && trap_kind == K_SPILL && cansave == '0));
  p_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_save && cansave != '0 && cleanwin == canrestore)
      |=> (trap_kind == K_CLEAN && canrestore == $past(canrestore)));
  p_balance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cansave} + {1'b0, canrestore}) == (CW+1)'(NWIN - 2));
  p_fill_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_back && !misal && canrestore == '0)
      |=> (trap_kind == K_FILL && cwp != $past(cwp) && canrestore == '0));
  p_align_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    misal |=> (trap_kind == K_ALIGN && cwp == $past(cwp) && cansave == $past(cansave)));
  p_no_we_on_trap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req == (trap_kind != K_NONE)) && !(rd_we && trap_req));
endmodule

// File: tb/regwin_ctrl_tb.sv
module regwin_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int CW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0;
  logic [1:0] op_kind = 2'b00, tgt_lo = 2'b00;
  logic [5:0] wstate = 6'd0;
  logic [CW-1:0] cleanwin = '0, otherwin = '0;
  logic [CW-1:0] cwp, cansave, canrestore;
  logic rd_we, trap_req, trap_other;
  logic [2:0] trap_kind, trap_vec;

  int n_chk = 0, n_bad = 0;
  int m_cwp, m_cs, m_cr;

  always #(CLK_PERIOD/2) clk = ~clk;

  regwin_ctrl #(.NWIN(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .tgt_lo(tgt_lo), .wstate(wstate), .cleanwin(cleanwin), .otherwin(otherwin),
    .cwp(cwp), .cansave(cansave), .canrestore(canrestore), .rd_we(rd_we),
    .trap_req(trap_req), .trap_kind(trap_kind), .trap_other(trap_other),
    .trap_vec(trap_vec));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // {valid, kind, tgt_lo, wstate, cleanwin, otherwin}
  localparam int NV = 11;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 2'd1, 2'd0, 6'o00, 3'd7, 3'd0},
    {1'b1, 2'd1, 2'd0, 6'o00, 3'd7, 3'd0},
    {1'b1, 2'd2, 2'd0, 6'o00, 3'd7, 3'd0},
    {1'b1, 2'd3, 2'd0, 6'o00, 3'd7, 3'd0},
    {1'b1, 2'd2, 2'd0, 6'o53, 3'd7, 3'd0},
    {1'b1, 2'd3, 2'd2, 6'o53, 3'd7, 3'd0},
    {1'b1, 2'd3, 2'd1, 6'o53, 3'd7, 3'd2},
    {1'b1, 2'd3, 2'd0, 6'o53, 3'd7, 3'd2},
    {1'b1, 2'd1, 2'd0, 6'o00, 3'd0, 3'd0},
    {1'b1, 2'd1, 2'd0, 6'o00, 3'd7, 3'd0},
    {1'b0, 2'd1, 2'd0, 6'o00, 3'd7, 3'd0}
  };

  task automatic run_op(input logic [16:0] s);
    int e_we = 0, e_kind = 0, e_oth = 0, e_vec = 0;
    int ow = int'(s[2:0]);
    int cw = int'(s[5:3]);
    logic [5:0] ws = s[11:6];
    logic [1:0] t = s[13:12];
    logic [1:0] k = s[15:14];
    string tag = "R2";
    if (s[16] && k == 2'd1) begin
      if (m_cs == 0) begin
        tag = "R4"; e_kind = 1; m_cwp = (m_cwp + 2) % N;
        e_oth = (ow != 0); e_vec = e_oth ? int'(ws[5:3]) : int'(ws[2:0]);
      end else if (cw == m_cr) begin
        tag = "R5"; e_kind = 3; m_cwp = (m_cwp + 1) % N;
      end else begin
        tag = "R3"; e_we = 1; m_cwp = (m_cwp + 1) % N; m_cs--; m_cr++;
      end
    end else if (s[16] && k[1]) begin
      if (k[0] && t != 2'd0) begin
        tag = "R9"; e_kind = 4;
      end else begin
        m_cwp = (m_cwp + N - 1) % N;
        if (m_cr == 0) begin
          tag = "R7"; e_kind = 2;
          e_oth = (ow != 0); e_vec = e_oth ? int'(ws[5:3]) : int'(ws[2:0]);
        end else begin
          tag = "R6"; e_we = 1; m_cs++; m_cr--;
        end
      end
    end
    @(negedge clk);
    op_valid = s[16]; op_kind = k; tgt_lo = t; wstate = ws;
    cleanwin = CW'(cw); otherwin = CW'(ow);
    @(negedge clk);
    chk(tag, "cwp", int'(cwp), m_cwp);
    chk(tag, "cansave", int'(cansave), m_cs);
    chk(tag, "canrestore", int'(canrestore), m_cr);
    chk(tag, "rd_we", int'(rd_we), e_we);
    chk(tag, "trap_kind", int'(trap_kind), e_kind);
    chk("R10", "trap_req", int'(trap_req), int'(e_kind != 0));
    chk("R8", "trap_other", int'(trap_other), e_oth);
    chk("R8", "trap_vec", int'(trap_vec), e_vec);
    op_valid = 1'b0;
    @(negedge clk);
    chk("R10", "pulse end", int'(trap_req) + int'(rd_we), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "cwp", int'(cwp), 0);
    chk("R1", "cansave", int'(cansave), N - 2);
    chk("R1", "canrestore", int'(canrestore), 0);
    chk("R1", "outputs", int'(rd_we) + int'(trap_req) + int'(trap_kind) + int'(trap_vec), 0);
    rst_n = 1'b1;
    m_cwp = 0; m_cs = N - 2; m_cr = 0;
    for (int i = 0; i < NV; i++) run_op(VEC[i]);
    // R2: valid with kind 00 does nothing
    run_op({1'b1, 2'd0, 2'd0, 6'o77, 3'd7, 3'd1});
    // exhaust the save counter (R3)
    for (int i = 0; i < 5; i++) run_op({1'b1, 2'd1, 2'd0, 6'o00, 3'd7, 3'd0});
    // R4: spill beats clean (cleanwin equals canrestore = 6), other kind
    run_op({1'b1, 2'd1, 2'd0, 6'o61, 3'd6, 3'd1});
    // R4 R8: spill normal kind, pointer wraps by two
    run_op({1'b1, 2'd1, 2'd0, 6'o61, 3'd7, 3'd0});
    // R6: walk back down, aligned returns
    for (int i = 0; i < 3; i++) run_op({1'b1, 2'd3, 2'd0, 6'o00, 3'd7, 3'd0});
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule